// File: doc/BRIEF.md
# Looping FM Envelope Generator

This block produces the attenuation envelope for one operator of an FM synthesis voice. On each audio sample, marked by a one-cycle strobe, it advances a four-phase envelope (attack, decay, sustain, release) held as a 10-bit attenuation, where 0 is loudest and 0x3FF is silent. It then forms the attenuation that goes to the operator's output stage. The envelope rate logic steps only on every third sample. Key handling, the looping mode and the output calculation act on every sample.

A looping mode is controlled by four bits: enable, start-inverted, alternate and hold. When the level crosses 0x200 in this mode, the block can restart the envelope, flip the output between direct and mirrored form, or freeze it. The block raises a one-cycle pulse whenever the operator's phase counter should restart. The rate tables are simplified to a shared tick counter with a per-rate mask and increment.

Top module: `loop_env_gen`

## Requirements
- R1: During and after reset, with no strobe yet seen, `att_out` is 0x3FF and `ph_restart` is 0. The internal level starts at 0x3FF in the release phase.
- R2: Samples are counted from reset. The rate-driven envelope step may run only on samples 0, 3, 6, and so on. Key events, looping actions and the output value are evaluated on every sample. `att_out` and `ph_restart` change only on the clock edge that takes a strobe and hold between strobes. On a sample that carries a key event, no rate-driven step runs.
- R3: The effective rate is 2×rate for attack, decay and sustain, and 0 when the rate field is 0. For release it is 4×rate+2. A rate of 0 never steps. For effective rates 48..63, a step happens on every update, and the increment is 1, 2, 4 or 8 for the groups starting at 48, 52, 56 and 60. Below 48 the increment is 1, and a step happens only when the low (11 − rate/4) bits of the update counter are zero.
- R4: An attack step lowers the level L by ((L×inc)>>4)+1, stopping at 0. Reaching 0 moves to decay, or to sustain when the sustain-level field is 0.
- R5: With attack rate field 31 (effective 62), a key-on or loop restart sets the level to 0 at once and enters decay, or sustain when the sustain-level field is 0. The attack phase is skipped.
- R6: On a key-on edge, the level is kept, the toggle flag is cleared, the envelope enters attack and `ph_restart` pulses. On a key-off edge, the envelope enters release.
- R7: In decay, an update at which the level is at or above sustain-level×32 switches to sustain without stepping. Decay, sustain and release steps saturate at 0x3FF.
- R8: With loop enable set, outside release, and the level at or above 0x200, the alternate bit toggles the flag on every sample. With hold also set, the flag can toggle only from 0 to 1.
- R9: Under the condition of R8 with hold clear, every sample restarts the envelope from attack (R5 applies) and pulses `ph_restart`.
- R10: Under the condition of R8 with hold set, the level is forced to 0x3FF when the output is not inverted after the toggle. With loop enable set and the level at or above 0x200 in release, the level is forced to 0x3FF.
- R11: Inversion is active when loop enable is set, the phase is not release, and the start-inverted bit XOR the flag is 1. A change of the start-inverted bit shows on the next sample.
- R12: `att_out` is min(0x3FF, E + total_level×8), where E is the level, or (0x200 − level) mod 0x400 when inverted. Total level is read on every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle pulse per audio sample |
| key_on | input | 1 | Key held level; edges are key-on and key-off |
| atk_rate | input | 5 | Attack rate field |
| dec_rate | input | 5 | Decay rate field |
| sus_rate | input | 5 | Sustain rate field |
| rel_rate | input | 4 | Release rate field |
| sus_lvl | input | 4 | Sustain level, in steps of 32 |
| tot_lvl | input | 7 | Total level, added as ×8 after inversion |
| loop_en | input | 1 | Looping mode enable |
| loop_inv | input | 1 | Start-inverted bit |
| loop_alt | input | 1 | Alternate bit |
| loop_hold | input | 1 | Hold bit |
| att_out | output | 10 | Effective attenuation |
| ph_restart | output | 1 | Phase counter restart pulse |

## Verification
The bench builds the block with its defaults: UPD_DIV=3, CNT_W=12, LVL_W=10 and TL_W=7. Update samples therefore fall at fixed multiples of three from reset, and rates in the top groups step on every update, so expected levels can be worked out sample by sample. Setting the attack rate to 0 freezes the level above 0x200. This isolates the per-sample looping actions (toggle, hold, restart, force and the live start-inverted bit) from the rate logic.

// File: rtl/loop_env_pkg.sv
// Shared types and helpers for the looping envelope generator.
// Assumes rate fields are 5 bits wide (release 4 bits) and effective rates 6 bits.
package loop_env_pkg;

    typedef enum logic [1:0] {
        PH_ATK = 2'd0,
        PH_DEC = 2'd1,
        PH_SUS = 2'd2,
        PH_REL = 2'd3
    } env_phase_e;

    localparam int RATE_W = 5;
    localparam int RREL_W = 4;
    localparam int SL_W   = 4;
    localparam int EFF_W  = 6;

    // Effective rate for attack, decay and sustain fields: zero stays zero
    function automatic logic [EFF_W-1:0] eff_of(input logic [RATE_W-1:0] r);
        return (r == '0) ? '0 : {r, 1'b0};
    endfunction

    // Effective rate for the release field
    function automatic logic [EFF_W-1:0] eff_rel(input logic [RREL_W-1:0] r);
        return {r, 2'b10};
    endfunction

endpackage

// File: rtl/env_tick_div.sv
// Sample divider: marks one of every UPD_DIV samples as an envelope update
// and counts those updates for the rate gate.
// Assumes smp_stb is a one-cycle pulse; counting starts at 0 after reset.
module env_tick_div #(
    parameter int UPD_DIV = 3,
    parameter int CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    output logic             upd,
    output logic [CNT_W-1:0] gcnt
);

    generate
        if (UPD_DIV <= 1) begin : g_every
            assign upd = smp_stb;
        end else begin : g_div
            localparam int DW = $clog2(UPD_DIV);
            localparam logic [DW-1:0] LAST = DW'(UPD_DIV - 1);
            logic [DW-1:0] sidx_q;

            // Position of the current sample inside the update period
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sidx_q <= '0;
                else if (smp_stb)
                    sidx_q <= (sidx_q == LAST) ? '0 : sidx_q + 1'b1;
            end

            assign upd = smp_stb && (sidx_q == '0);
        end
    endgenerate

    // Shared update counter, advanced once per update sample
    always_ff @(posedge clk) begin
        if (!rst_n)
            gcnt <= '0;
        else if (upd)
            gcnt <= gcnt + 1'b1;
    end

endmodule

// File: rtl/env_rate_gate.sv
// Rate gate: decides from an effective rate and the update counter whether
// the envelope steps on this update, and by how much.
// Assumes a 6-bit effective rate; rate groups 12..15 step on every update.
module env_rate_gate #(
    parameter int CNT_W = 12
) (
    input  logic [5:0]       eff,
    input  logic [CNT_W-1:0] gcnt,
    output logic             step,
    output logic [3:0]       inc
);

    logic [3:0]       grp;
    logic [3:0]       sh;
    logic [CNT_W-1:0] mask;

    assign grp = eff[5:2];

    // Shift and increment from the rate group
    always_comb begin
        if (grp >= 4'd12) begin
            sh  = 4'd0;
            inc = 4'd1 << grp[1:0];
        end else begin
            sh  = 4'd11 - grp;
            inc = 4'd1;
        end
        for (int i = 0; i < CNT_W; i++)
            mask[i] = (i < int'(sh));
        step = (eff != '0) && ((gcnt & mask) == '0);
    end

endmodule

// File: rtl/loop_env_gen.sv
// Per-operator envelope generator with a looping/inverting mode.
// Per sample: key events or looping actions first, then the rate-driven step
// (one sample in UPD_DIV), then the output attenuation, all registered at once.
// Assumes one smp_stb pulse per sample and LVL_W >= TL_W + 1.
module loop_env_gen
    import loop_env_pkg::*;
#(
    parameter int LVL_W   = 10,
    parameter int TL_W    = 7,
    parameter int CNT_W   = 12,
    parameter int UPD_DIV = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              key_on,
    input  logic [4:0]        atk_rate,
    input  logic [4:0]        dec_rate,
    input  logic [4:0]        sus_rate,
    input  logic [3:0]        rel_rate,
    input  logic [3:0]        sus_lvl,
    input  logic [TL_W-1:0]   tot_lvl,
    input  logic              loop_en,
    input  logic              loop_inv,
    input  logic              loop_alt,
    input  logic              loop_hold,
    output logic [LVL_W-1:0]  att_out,
    output logic              ph_restart
);

    localparam logic [LVL_W-1:0] LVL_MAX = '1;
    localparam logic [LVL_W-1:0] HALF    = LVL_W'(1) << (LVL_W - 1);
    localparam int               SL_SH   = LVL_W - 5;
    localparam int               TL_SH   = LVL_W - TL_W;

    env_phase_e        phase_q, ph_a, ph_b;
    logic [LVL_W-1:0]  lvl_q, lv_a, lv_b;
    logic              flag_q, fl_a, rs_a;
    logic              key_q;

    logic              upd;
    logic [CNT_W-1:0]  gcnt;
    logic [EFF_W-1:0]  eff_sel;
    logic              step;
    logic [3:0]        inc;

    logic              k_on, k_off, ar_fast, sl_zero;
    logic [LVL_W-1:0]  sl_tgt, tl_sh, e_lvl, sub;
    logic [LVL_W+3:0]  prod;
    logic [LVL_W:0]    sum, addv;
    logic              inv;
    logic [LVL_W-1:0]  out_nx;

    env_tick_div #(.UPD_DIV(UPD_DIV), .CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_stb(smp_stb),
        .upd    (upd),
        .gcnt   (gcnt)
    );

    env_rate_gate #(.CNT_W(CNT_W)) u_gate (
        .eff (eff_sel),
        .gcnt(gcnt),
        .step(step),
        .inc (inc)
    );

    assign k_on    = key_on && !key_q;
    assign k_off   = !key_on && key_q;
    assign ar_fast = (atk_rate == 5'd31);
    assign sl_zero = (sus_lvl == '0);
    assign sl_tgt  = LVL_W'(sus_lvl) << SL_SH;
    assign tl_sh   = LVL_W'(tot_lvl) << TL_SH;

    // Stage A: key events, or looping actions when no key event
    always_comb begin
        ph_a = phase_q;
        lv_a = lvl_q;
        fl_a = flag_q;
        rs_a = 1'b0;
        if (k_on) begin
            fl_a = 1'b0;
            rs_a = 1'b1;
            if (ar_fast) begin
                lv_a = '0;
                ph_a = sl_zero ? PH_SUS : PH_DEC;
            end else begin
                ph_a = PH_ATK;
            end
        end else if (k_off) begin
            ph_a = PH_REL;
        end else if (loop_en && (lvl_q >= HALF)) begin
            if (phase_q != PH_REL) begin
                if (loop_alt && !(loop_hold && flag_q))
                    fl_a = !flag_q;
                if (!loop_hold) begin
                    rs_a = 1'b1;
                    if (ar_fast) begin
                        lv_a = '0;
                        ph_a = sl_zero ? PH_SUS : PH_DEC;
                    end else begin
                        ph_a = PH_ATK;
                    end
                end else if (!(loop_inv ^ fl_a)) begin
                    lv_a = LVL_MAX;
                end
            end else begin
                lv_a = LVL_MAX;
            end
        end
    end

    // Rate selection from the phase left by stage A
    always_comb begin
        unique case (ph_a)
            PH_ATK:  eff_sel = eff_of(atk_rate);
            PH_DEC:  eff_sel = eff_of(dec_rate);
            PH_SUS:  eff_sel = eff_of(sus_rate);
            default: eff_sel = eff_rel(rel_rate);
        endcase
    end

    // Stage B: rate-driven envelope step on update samples without key events
    always_comb begin
        ph_b = ph_a;
        lv_b = lv_a;
        prod = (LVL_W+4)'(lv_a) * (LVL_W+4)'(inc);
        sub  = prod[LVL_W+3:4] + 1'b1;
        addv = {1'b0, lv_a} + (LVL_W+1)'(inc);
        if (upd && !k_on && !k_off) begin
            unique case (ph_a)
                PH_ATK: begin
                    if (!ar_fast && step) begin
                        if (sub >= lv_a) begin
                            lv_b = '0;
                            ph_b = sl_zero ? PH_SUS : PH_DEC;
                        end else begin
                            lv_b = lv_a - sub;
                        end
                    end
                end
                PH_DEC: begin
                    if (lv_a >= sl_tgt)
                        ph_b = PH_SUS;
                    else if (step)
                        lv_b = addv[LVL_W] ? LVL_MAX : addv[LVL_W-1:0];
                end
                default: begin
                    if (step)
                        lv_b = addv[LVL_W] ? LVL_MAX : addv[LVL_W-1:0];
                end
            endcase
        end
    end

    // Stage C: inversion, total level and saturation
    always_comb begin
        inv    = loop_en && (ph_b != PH_REL) && (loop_inv ^ fl_a);
        e_lvl  = inv ? (HALF - lv_b) : lv_b;
        sum    = {1'b0, e_lvl} + {1'b0, tl_sh};
        out_nx = sum[LVL_W] ? LVL_MAX : sum[LVL_W-1:0];
    end

    // State and output registers, advanced once per sample strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_REL;
            lvl_q      <= LVL_MAX;
            flag_q     <= 1'b0;
            key_q      <= 1'b0;
            att_out    <= LVL_MAX;
            ph_restart <= 1'b0;
        end else begin
            ph_restart <= smp_stb && rs_a;
            if (smp_stb) begin
                phase_q <= ph_b;
                lvl_q   <= lv_b;
                flag_q  <= fl_a;
                key_q   <= key_on;
                att_out <= out_nx;
            end
        end
    end

endmodule

// File: rtl/loop_env_gen_chk.sv
// Checker for loop_env_gen: port-level timing and output relations.
// Assumes it is bound into loop_env_gen so key_q is the sampled key state.
module loop_env_gen_chk #(
    parameter int LVL_W = 10,
    parameter int TL_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic             key_on,
    input logic             key_q,
    input logic             loop_inv,
    input logic [4:0]       atk_rate,
    input logic [TL_W-1:0]  tot_lvl,
    input logic [LVL_W-1:0] att_out,
    input logic             ph_restart
);

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(att_out));

    // R6
    restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_restart |-> $past(smp_stb));

    // R6
    keyon_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && key_on && !key_q) |=> ph_restart);

    // R5
    fast_attack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && key_on && !key_q && (atk_rate == 5'd31) && !loop_inv && (tot_lvl == '0))
        |=> (att_out == '0));

    // R12
    tl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (att_out >= (LVL_W'($past(tot_lvl)) << (LVL_W - TL_W))));

endmodule

bind loop_env_gen loop_env_gen_chk #(.LVL_W(LVL_W), .TL_W(TL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .key_on    (key_on),
    .key_q     (key_q),
    .loop_inv  (loop_inv),
    .atk_rate  (atk_rate),
    .tot_lvl   (tot_lvl),
    .att_out   (att_out),
    .ph_restart(ph_restart)
);

// File: tb/sim_loop_env_gen.sv
// Self-checking bench: a vector table walked in one loop, then directed tests.
module sim_loop_env_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic       key_on = 1'b0;
    logic [4:0] atk_rate = '0, dec_rate = '0, sus_rate = '0;
    logic [3:0] rel_rate = '0, sus_lvl = '0;
    logic [6:0] tot_lvl = '0;
    logic       loop_en = 1'b0, loop_inv = 1'b0, loop_alt = 1'b0, loop_hold = 1'b0;
    logic [9:0] att_out;
    logic       ph_restart;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    loop_env_gen u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .key_on(key_on),
        .atk_rate(atk_rate), .dec_rate(dec_rate), .sus_rate(sus_rate),
        .rel_rate(rel_rate), .sus_lvl(sus_lvl), .tot_lvl(tot_lvl),
        .loop_en(loop_en), .loop_inv(loop_inv), .loop_alt(loop_alt),
        .loop_hold(loop_hold), .att_out(att_out), .ph_restart(ph_restart)
    );

    typedef struct packed {
        logic [4:0] ar;
        logic [4:0] dr;
        logic [4:0] sr;
        logic [3:0] rr;
        logic [3:0] sl;
        logic [6:0] tl;
        logic       key;
        logic [7:0] n;
        logic [9:0] exp_v;
        logic [3:0] req;
    } row_t;

    // Rows run in sequence from one reset; sample indices noted per row.
    localparam row_t ROWS [9] = '{
        '{5'd31, 5'd30, 5'd0,  4'd15, 4'd15, 7'd0, 1'b1, 8'd4,  10'd8,  4'd5},  // R5 s0 key-on to 0, s3 +8
        '{5'd31, 5'd30, 5'd0,  4'd15, 4'd15, 7'd4, 1'b1, 8'd3,  10'd48, 4'd12}, // R12 s6 16 + 32
        '{5'd31, 5'd30, 5'd0,  4'd15, 4'd15, 7'd0, 1'b0, 8'd1,  10'd16, 4'd6},  // R6 s7 key-off, no step
        '{5'd31, 5'd30, 5'd0,  4'd15, 4'd15, 7'd0, 1'b0, 8'd2,  10'd24, 4'd3},  // R3 s9 release +8
        '{5'd31, 5'd30, 5'd0,  4'd15, 4'd15, 7'd0, 1'b0, 8'd3,  10'd32, 4'd2},  // R2 s12 only
        '{5'd28, 5'd0,  5'd24, 4'd15, 4'd0,  7'd0, 1'b1, 8'd1,  10'd32, 4'd6},  // R6 s13 key-on keeps level
        '{5'd28, 5'd0,  5'd24, 4'd15, 4'd0,  7'd0, 1'b1, 8'd2,  10'd23, 4'd4},  // R4 s15 32-9
        '{5'd28, 5'd0,  5'd24, 4'd15, 4'd0,  7'd0, 1'b1, 8'd3,  10'd17, 4'd4},  // R4 s18 23-6
        '{5'd28, 5'd0,  5'd24, 4'd15, 4'd0,  7'd0, 1'b1, 8'd24, 10'd1,  4'd4}   // R4 s39 to 0 then sustain +1
    };

    task automatic check(input string req, input int got, input int expv);
        checks++;
        if (got !== expv) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, expv);
        end
    endtask

    // One sample strobe; returns at the negedge after the edge that took it
    task automatic do_sample();
        @(negedge clk) smp_stb = 1'b1;
        @(negedge clk) smp_stb = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) do_sample();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_stb = 1'b0; key_on = 1'b0;
        atk_rate = '0; dec_rate = '0; sus_rate = '0; rel_rate = '0;
        sus_lvl = '0; tot_lvl = '0;
        loop_en = 1'b0; loop_inv = 1'b0; loop_alt = 1'b0; loop_hold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset values
        do_reset();
        @(negedge clk);
        check("R1 att_out", int'(att_out), 1023);
        check("R1 ph_restart", int'(ph_restart), 0);

        // Table walk
        for (int r = 0; r < 9; r++) begin
            atk_rate = ROWS[r].ar; dec_rate = ROWS[r].dr; sus_rate = ROWS[r].sr;
            rel_rate = ROWS[r].rr; sus_lvl = ROWS[r].sl; tot_lvl = ROWS[r].tl;
            key_on = ROWS[r].key;
            run(int'(ROWS[r].n));
            check($sformatf("R%0d row%0d", ROWS[r].req, r), int'(att_out), int'(ROWS[r].exp_v));
        end

        // R8 R9: alternate without hold toggles and restarts every sample
        do_reset();
        loop_en = 1'b1; loop_alt = 1'b1; key_on = 1'b1;
        do_sample();
        check("R6 key-on pulse", int'(ph_restart), 1);
        check("R6 key-on level kept", int'(att_out), 1023);
        do_sample();
        check("R8 toggled inverted", int'(att_out), 513);
        check("R9 loop restart pulse", int'(ph_restart), 1);
        do_sample();
        check("R8 toggled back", int'(att_out), 1023);
        check("R9 restart again", int'(ph_restart), 1);

        // R8 R11: hold+alternate toggles once; start-inverted bit acts live
        do_reset();
        loop_en = 1'b1; loop_alt = 1'b1; loop_hold = 1'b1; key_on = 1'b1;
        do_sample();
        do_sample();
        check("R8 hold first toggle", int'(att_out), 513);
        check("R9 hold no restart", int'(ph_restart), 0);
        do_sample();
        check("R8 hold no second toggle", int'(att_out), 513);
        loop_inv = 1'b1;
        do_sample();
        check("R11 inv bit flips output", int'(att_out), 1023);
        loop_inv = 1'b0;
        do_sample();
        check("R11 inv bit flips back", int'(att_out), 513);

        // R10 R12: hold forcing from a level between 0x200 and 0x3FF
        do_reset();
        atk_rate = 5'd28; key_on = 1'b1;
        run(7);
        check("R4 attack from 1023", int'(att_out), 575);
        atk_rate = 5'd0; loop_en = 1'b1; loop_hold = 1'b1; loop_inv = 1'b1;
        do_sample();
        check("R12 inverted level", int'(att_out), 961);
        loop_inv = 1'b0;
        do_sample();
        check("R10 hold force", int'(att_out), 1023);

        // R10 R11: release forcing, inversion off in release
        do_reset();
        atk_rate = 5'd28; rel_rate = 4'd15; key_on = 1'b1;
        run(4);
        key_on = 1'b0;
        do_sample();
        check("R6 key-off keeps level", int'(att_out), 767);
        loop_en = 1'b1; loop_inv = 1'b1; loop_alt = 1'b1;
        do_sample();
        check("R10 release force", int'(att_out), 1023);
        check("R11 release no restart", int'(ph_restart), 0);

        // R7: decay to sustain at sustain level
        do_reset();
        atk_rate = 5'd31; dec_rate = 5'd30; sus_lvl = 4'd1; key_on = 1'b1;
        run(19);
        check("R7 decay stops at target", int'(att_out), 32);

        // R7: clamp in release
        do_reset();
        rel_rate = 4'd15;
        run(4);
        check("R7 release clamp", int'(att_out), 1023);

        // R12 R5: total level saturation
        do_reset();
        atk_rate = 5'd31; dec_rate = 5'd30; sus_lvl = 4'd15; tot_lvl = 7'd127; key_on = 1'b1;
        do_sample();
        check("R5 fast attack with tl", int'(att_out), 1016);
        run(3);
        check("R12 saturation", int'(att_out), 1023);

        finish_run();
    end

endmodule